// File: doc/BRIEF.md
# Four-Channel PWM with Pair Joining

This block produces four pulse-width modulated waveforms from four 8-bit channels. Each channel has a free-running counter, a period value and a duty value. The counter restarts whenever it reaches the end of its period. The output is active while the count is below the duty value. Each channel can pick one of two shared tick sources: a binary-prescaled tick B, or a slower tick S that is derived from B. Each channel can also pick its output polarity.

Two control bits join the channels into 16-bit pairs: channels 0 and 1 form one pair, and channels 2 and 3 form the other. In a joined pair the first channel holds the high byte of the counter, period and duty. The second channel drives the waveform on its own pin and supplies the tick source and the polarity. The pin of the high-byte channel is held low while the pair is joined.

Software programs the block through a simple write port and a combinational read port. Period and duty changes are held back until the current period ends, so a write never produces a truncated pulse.

Top module: `pwm4_concat`

## Requirements
- R1: A channel counter advances by one on each tick of its selected source. After reaching period-1 it returns to 0, so a period of P gives P ticks per cycle. A period of 0 holds the counter at 0.
- R2: The active condition holds while count < duty. A duty of 0 keeps the output inactive all the time. A duty greater than or equal to the period keeps the output active all the time.
- R3: A polarity bit of 1 drives the pin high while active and low while inactive. A polarity bit of 0 inverts both levels.
- R4: Tick B occurs once every 2^n clocks, where n is the 3-bit prescale exponent. Tick S occurs once every (m+1) B ticks, where m is the 8-bit scaler value. A channel's clock-select bit chooses B when 0 and S when 1.
- R5: Period and duty writes are held pending until the running period ends. A counter write also loads the pending values at once.
- R6: Writing any value to a channel's counter address clears that counter to 0 on the next clock edge. This clear takes priority over a tick.
- R7: Control bit 1 joins channels 2 and 3 into a 16-bit channel. In the joined channel, channel 2 supplies the high byte of count, period and duty. Channel 3 supplies the low byte, the tick select and the polarity, and drives pin 3. Pin 2 is held at 0.
- R8: Control bit 0 joins channels 0 and 1 in the same way. Channel 0 is the high byte, channel 1 drives pin 1, and pin 0 is held at 0.
- R9: After reset, all registers and counters read 0 except the polarity register, which reads 0x0F. All pins are 0.
- R10: The address map is as follows. Addresses 0 to 3 hold the periods of channels 0 to 3. Addresses 4 to 7 hold the duties. Addresses 8 to 11 hold the counters: a write clears the counter and a read returns the live count. Address 12 is the control register, with bit 0 joining channels 0 and 1, bit 1 joining channels 2 and 3, and bits 6:4 holding the prescale exponent. Address 13 holds the polarity bits in 3:0. Address 14 holds the clock-select bits in 3:0. Address 15 holds the scaler value. Every register reads back what was written, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| pwm_out | output | 4 | Waveform pins, one per channel |

## Verification
The assertions check four behaviours on every cycle:
- a counter write clears the counter on the next cycle;
- a counter only steps by one, holds, or returns to zero;
- the B tick never fires on two consecutive cycles when the divider is above one;
- the high-byte pin of a joined pair stays low.

Duty ratios, pulse counts per window, deferred loading of period and duty, and the effect of tick and polarity selection can only be seen over many periods. The bench scenarios measure these by counting high cycles and rising edges across whole periods.

// File: rtl/pwm_pkg.sv
// Package: shared constants for the four-channel PWM.
// Assumes four channels of 8 bits and a 4-bit register address.
package pwm_pkg;
    localparam int NCH   = 4;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int EXP_W = 3;
    localparam int NPAIR = NCH / 2;
    // register group selected by address bits [3:2]
    localparam logic [1:0] GRP_PER = 2'd0;
    localparam logic [1:0] GRP_DTY = 2'd1;
    localparam logic [1:0] GRP_CNT = 2'd2;
    localparam logic [1:0] GRP_MSC = 2'd3;
    // misc registers selected by address bits [1:0]
    localparam logic [1:0] MSC_CTRL = 2'd0;
    localparam logic [1:0] MSC_POL  = 2'd1;
    localparam logic [1:0] MSC_CSEL = 2'd2;
    localparam logic [1:0] MSC_SVAL = 2'd3;
endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Generates tick B every 2^bexp clocks and tick S every (sval+1) B ticks.
// Assumes bexp < CNT_W so the mask never covers the whole counter.
module pwm_prescaler #(
    parameter int CNT_W = 8,
    parameter int EXP_W = 3,
    parameter int SC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] bexp,
    input  logic [SC_W-1:0]  sval,
    output logic             tick_b,
    output logic             tick_s
);
    logic [CNT_W-1:0] pcnt;
    logic [SC_W-1:0]  scnt;
    logic [CNT_W-1:0] mask;

    // Decode the low-bit mask that sets the B division
    always_comb begin
        mask   = ~({CNT_W{1'b1}} << bexp);
        tick_b = (pcnt & mask) == mask;
        tick_s = tick_b && (scnt >= sval);
    end

    // Free-running divider counter
    always_ff @(posedge clk) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= pcnt + 1'b1;
    end

    // Count B ticks toward the next S tick
    always_ff @(posedge clk) begin
        if (!rst_n)      scnt <= '0;
        else if (tick_s) scnt <= '0;
        else if (tick_b) scnt <= scnt + 1'b1;
    end
endmodule

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Register file: periods, duties, control, polarity, clock select and scaler.
// Also decodes counter-clear strobes and multiplexes read data.
// Assumes NCH = 4 so that address bits [3:2] select a register group.
module pwm_regs
    import pwm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    input  logic [NCH-1:0][DW-1:0]  cnt,
    output logic [NCH-1:0][DW-1:0]  per,
    output logic [NCH-1:0][DW-1:0]  dty,
    output logic [NPAIR-1:0]        join_en,
    output logic [EXP_W-1:0]        bexp,
    output logic [NCH-1:0]          pol,
    output logic [NCH-1:0]          csel,
    output logic [DW-1:0]           sval,
    output logic [NCH-1:0]          clr
);
    localparam int IW = $clog2(NCH);

    logic [1:0]    wgrp;
    logic [IW-1:0] widx;
    logic [1:0]    rgrp;
    logic [IW-1:0] ridx;

    assign wgrp = wr_addr[AW-1:AW-2];
    assign widx = wr_addr[IW-1:0];
    assign rgrp = rd_addr[AW-1:AW-2];
    assign ridx = rd_addr[IW-1:0];

    // Store register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per     <= '0;
            dty     <= '0;
            join_en <= '0;
            bexp    <= '0;
            pol     <= '1;
            csel    <= '0;
            sval    <= '0;
        end else if (wr_en) begin
            case (wgrp)
                GRP_PER: per[widx] <= wr_data;
                GRP_DTY: dty[widx] <= wr_data;
                GRP_MSC: begin
                    case (wr_addr[1:0])
                        MSC_CTRL: begin
                            join_en <= wr_data[NPAIR-1:0];
                            bexp    <= wr_data[4 +: EXP_W];
                        end
                        MSC_POL:  pol  <= wr_data[NCH-1:0];
                        MSC_CSEL: csel <= wr_data[NCH-1:0];
                        default:  sval <= wr_data;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // One-cycle clear strobe per counter address
    always_comb begin
        clr = '0;
        if (wr_en && wgrp == GRP_CNT) clr[widx] = 1'b1;
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        case (rgrp)
            GRP_PER: rd_data = per[ridx];
            GRP_DTY: rd_data = dty[ridx];
            GRP_CNT: rd_data = cnt[ridx];
            default: begin
                case (rd_addr[1:0])
                    MSC_CTRL: begin
                        rd_data[NPAIR-1:0]   = join_en;
                        rd_data[4 +: EXP_W]  = bexp;
                    end
                    MSC_POL:  rd_data[NCH-1:0] = pol;
                    MSC_CSEL: rd_data[NCH-1:0] = csel;
                    default:  rd_data = sval;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/pwm_pair.sv
// Module: pwm_pair
// Two W-bit PWM channels that can be joined into one 2W-bit channel.
// Index 0 is the high-byte channel; index 1 drives the output when joined
// and supplies the tick select and polarity. Period and duty are copied
// into shadow registers at the end of each period or on a counter clear.
module pwm_pair #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_b,
    input  logic                tick_s,
    input  logic                joined,
    input  logic [1:0]          csel,
    input  logic [1:0]          pol,
    input  logic [1:0][W-1:0]   per,
    input  logic [1:0][W-1:0]   dty,
    input  logic [1:0]          clr,
    output logic [1:0][W-1:0]   cnt,
    output logic [1:0]          pin
);
    localparam int W2 = 2 * W;

    logic [1:0][W-1:0] cnt_q;
    logic [1:0][W-1:0] sp;
    logic [1:0][W-1:0] sd;
    logic [1:0]        tk;
    logic [1:0]        at_end;
    logic [1:0]        act;
    logic [W2-1:0]     c16;
    logic [W2-1:0]     sp16;
    logic [W2-1:0]     sd16;
    logic              end16;
    logic              act16;
    logic              lo_act;

    // Per-channel tick choice, end-of-period and compare
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            tk[i]     = csel[i] ? tick_s : tick_b;
            at_end[i] = (sp[i] == '0) || (cnt_q[i] == sp[i] - 1'b1);
            act[i]    = cnt_q[i] < sd[i];
        end
        c16   = {cnt_q[0], cnt_q[1]};
        sp16  = {sp[0], sp[1]};
        sd16  = {sd[0], sd[1]};
        end16 = (sp16 == '0) || (c16 == sp16 - 1'b1);
        act16 = c16 < sd16;
    end

    // Counter and shadow update, joined or separate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sp    <= '0;
            sd    <= '0;
        end else if (joined) begin
            if (|clr) begin
                cnt_q <= '0;
                sp    <= per;
                sd    <= dty;
            end else if (tk[1]) begin
                if (end16) begin
                    cnt_q <= '0;
                    sp    <= per;
                    sd    <= dty;
                end else begin
                    {cnt_q[0], cnt_q[1]} <= c16 + 1'b1;
                end
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (clr[i] || (tk[i] && at_end[i])) begin
                    cnt_q[i] <= '0;
                    sp[i]    <= per[i];
                    sd[i]    <= dty[i];
                end else if (tk[i]) begin
                    cnt_q[i] <= cnt_q[i] + 1'b1;
                end
            end
        end
    end

    // Pin levels with polarity; high-byte pin parked low when joined
    always_comb begin
        lo_act = joined ? act16 : act[1];
        pin[1] = pol[1] ? lo_act : ~lo_act;
        pin[0] = joined ? 1'b0 : (pol[0] ? act[0] : ~act[0]);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pwm4_concat.sv
// Module: pwm4_concat (top)
// Four 8-bit PWM channels, joinable in pairs, with a register port.
// Assumes the package constants: four channels, 8-bit data, 4-bit address.
module pwm4_concat
    import pwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [3:0]    rd_addr,
    output logic [7:0]    rd_data,
    output logic [3:0]    pwm_out
);
    logic [NCH-1:0][DW-1:0] cnt_all;
    logic [NCH-1:0][DW-1:0] per_all;
    logic [NCH-1:0][DW-1:0] dty_all;
    logic [NPAIR-1:0]       cfg_join;
    logic [EXP_W-1:0]       cfg_bexp;
    logic [NCH-1:0]         cfg_pol;
    logic [NCH-1:0]         cfg_csel;
    logic [DW-1:0]          cfg_sval;
    logic [NCH-1:0]         clr;
    logic                   tick_b;
    logic                   tick_s;

    pwm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cnt     (cnt_all),
        .per     (per_all),
        .dty     (dty_all),
        .join_en (cfg_join),
        .bexp    (cfg_bexp),
        .pol     (cfg_pol),
        .csel    (cfg_csel),
        .sval    (cfg_sval),
        .clr     (clr)
    );

    pwm_prescaler #(.CNT_W(8), .EXP_W(EXP_W), .SC_W(DW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .bexp   (cfg_bexp),
        .sval   (cfg_sval),
        .tick_b (tick_b),
        .tick_s (tick_s)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [1:0][DW-1:0] pcnt;
        logic [1:0]         ppin;

        pwm_pair #(.W(DW)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_b (tick_b),
            .tick_s (tick_s),
            .joined (cfg_join[p]),
            .csel   (cfg_csel[2*p +: 2]),
            .pol    (cfg_pol[2*p +: 2]),
            .per    (per_all[2*p +: 2]),
            .dty    (dty_all[2*p +: 2]),
            .clr    (clr[2*p +: 2]),
            .cnt    (pcnt),
            .pin    (ppin)
        );

        assign cnt_all[2*p +: 2] = pcnt;
        assign pwm_out[2*p +: 2] = ppin;
    end
endmodule

// File: rtl/pwm4_concat_chk.sv
// Module: pwm4_concat_chk
// Cycle-by-cycle properties for pwm4_concat, attached through bind.
// Assumes channel 0 and channel 3 counters are brought out by the top.
module pwm4_concat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [1:0] join_en,
    input logic [2:0] bexp,
    input logic       tick_b,
    input logic [3:0] pwm_out,
    input logic [7:0] cnt0,
    input logic [7:0] cnt3
);
    // R6
    cnt0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd8) |=> (cnt0 == 8'd0));

    // R6
    cnt3_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd11) |=> (cnt3 == 8'd0));

    // R1
    cnt0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt0 == 8'd0 || cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 8'd1));

    // R1
    cnt3_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt3 == 8'd0 || cnt3 == $past(cnt3) || cnt3 == $past(cnt3) + 8'd1));

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_b && bexp != 3'd0) |=> (!tick_b || bexp != $past(bexp)));

    // R8
    hi01_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_en[0] |-> (pwm_out[0] == 1'b0));

    // R7
    hi23_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_en[1] |-> (pwm_out[2] == 1'b0));
endmodule

bind pwm4_concat pwm4_concat_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .join_en (cfg_join),
    .bexp    (cfg_bexp),
    .tick_b  (tick_b),
    .pwm_out (pwm_out),
    .cnt0    (cnt_all[0]),
    .cnt3    (cnt_all[3])
);

// File: tb/pwm4_concat_bench.sv
`timescale 1ns/1ps
module pwm4_concat_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] pwm_out;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm4_concat u_pwm4_concat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [1:0]  ch;    // output channel (low channel when joined)
        logic [1:0]  jn;    // control join bits
        logic [15:0] per;
        logic [15:0] dty;
        logic        pol;
        logic        csel;
        logic [2:0]  bexp;
        logic [7:0]  sval;
        logic [15:0] win;   // whole periods, in clocks
        logic [15:0] hi;    // expected high clocks in window
        logic [7:0]  rise;  // expected rising edges in window
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 16'd10,  16'd3,   1'b1, 1'b0, 3'd0, 8'd0, 16'd40,   16'd12,   8'd4}, // R1 R2
        '{2'd1, 2'd0, 16'd8,   16'd6,   1'b0, 1'b0, 3'd1, 8'd0, 16'd48,   16'd12,   8'd3}, // R3 R4
        '{2'd2, 2'd0, 16'd5,   16'd0,   1'b1, 1'b0, 3'd0, 8'd0, 16'd40,   16'd0,    8'd0}, // R2 duty 0
        '{2'd3, 2'd0, 16'd6,   16'd9,   1'b1, 1'b0, 3'd0, 8'd0, 16'd36,   16'd36,   8'd0}, // R2 duty>=period
        '{2'd0, 2'd0, 16'd12,  16'd12,  1'b0, 1'b0, 3'd0, 8'd0, 16'd48,   16'd0,    8'd0}, // R3 always active, inverted
        '{2'd1, 2'd0, 16'd4,   16'd1,   1'b1, 1'b1, 3'd0, 8'd2, 16'd24,   16'd6,    8'd2}, // R4 tick S
        '{2'd2, 2'd0, 16'd3,   16'd2,   1'b1, 1'b0, 3'd3, 8'd0, 16'd48,   16'd32,   8'd2}, // R4 tick B /8
        '{2'd1, 2'd1, 16'd260, 16'd130, 1'b1, 1'b0, 3'd0, 8'd0, 16'd520,  16'd260,  8'd2}, // R8
        '{2'd3, 2'd2, 16'd512, 16'd256, 1'b1, 1'b1, 3'd0, 8'd1, 16'd2048, 16'd1024, 8'd2}  // R7
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = a[3:0];
        wr_data = d[7:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_cnt(input int target);
        for (int k = 0; k < 2000; k++) begin
            if (rd_data == target[7:0]) return;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int hi = 0, rise = 0, parked = 0;
        logic prev;
        int c = int'(v.ch);
        wr(12, {1'b0, v.bexp, 2'b00, v.jn});
        wr(13, v.pol ? 4'hF : (4'hF & ~(4'b1 << c)));
        wr(14, v.csel ? (1 << c) : 0);
        wr(15, v.sval);
        if (v.jn != 0) begin
            wr(c - 1, v.per[15:8]);
            wr(c - 1 + 4, v.dty[15:8]);
        end
        wr(c, v.per[7:0]);
        wr(c + 4, v.dty[7:0]);
        wr(c + 8, 0);
        repeat (4) @(negedge clk);
        prev = pwm_out[c];
        for (int k = 0; k < int'(v.win); k++) begin
            @(negedge clk);
            if (pwm_out[c]) hi++;
            if (pwm_out[c] && !prev) rise++;
            prev = pwm_out[c];
            if (v.jn != 0 && pwm_out[c - 1]) parked++;
        end
        $display("vector %0d", idx);
        check(v.jn != 0 ? "R7/R8 high time" : "R2/R3/R4 high time", hi, int'(v.hi));
        check("R1 rising edges per window", rise, int'(v.rise));
        if (v.jn != 0) check("R7/R8 high-byte pin parked", parked, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 pins after reset", int'(pwm_out), 0);
        rd_addr = 4'd13; #0.1;
        check("R9 polarity reset", int'(rd_data), 8'h0F);
        rd_addr = 4'd0; #0.1;
        check("R9 period reset", int'(rd_data), 0);
        // R10 readback
        wr(15, 8'h5A);
        rd_addr = 4'd15; #0.1;
        check("R10 scaler readback", int'(rd_data), 8'h5A);
        wr(12, 8'h73);
        rd_addr = 4'd12; #0.1;
        check("R10 control readback", int'(rd_data), 8'h73);
        wr(12, 0);
        wr(15, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // Directed: channel 0, period 100, duty 50
        wr(12, 0); wr(13, 4'hF); wr(14, 0); wr(15, 0);
        wr(0, 100); wr(4, 50);
        rd_addr = 4'd8;
        wr(8, 0);
        check("R6 counter cleared by write", int'(rd_data), 0);
        @(negedge clk);
        check("R1 counter advances on tick", int'(rd_data), 1);
        wait_cnt(20);
        check("R2 active below duty", int'(pwm_out[0]), 1);
        wait_cnt(60);
        check("R2 inactive at or above duty", int'(pwm_out[0]), 0);
        wr(4, 90);
        wait_cnt(70);
        check("R5 duty change deferred", int'(pwm_out[0]), 0);
        wait_cnt(99);
        @(negedge clk);
        check("R1 wrap after period-1", int'(rd_data), 0);
        wait_cnt(70);
        check("R5 duty change applied next period", int'(pwm_out[0]), 1);
        rd_addr = 4'd4; #0.1;
        check("R10 duty readback", int'(rd_data), 90);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule